// File: doc/BRIEF.md
# I2C Target Header-Response Controller

This block holds the control and decision logic of an I2C target. A bit-level layer reports two events to it: a received address header, which carries the result of an address comparison and the R/W bit, and the end of a data byte. For each event the block either answers at once with an ACK or NACK decision, or stalls the bus and raises a pending flag until software writes a continue strobe into its control register. While a data phase runs it also raises transmit or receive DMA requests toward the byte datapath.

The control register is 32 bits wide. Bit 0 is the continue strobe and bit 1 the refuse (NACK) strobe; both act only on the write that carries them and read back as 0. Bit 3 enables DMA, bit 8 enables automatic acknowledge, and bit 9 selects the expected direction for automatic acknowledge (1 = read, 0 = write). These three store their value and read it back. All other bits are reserved, read as 0, and the register resets to 0. The auto-NACK choice arrives on its own input pin from a separate address register.

The sequencer has five states. IDLE is the state with no transfer open. TX_PHASE is a read transfer, where the target transmits. RX_PHASE is a write transfer, where the target receives. HDR_WAIT is a stall on a header, and BYTE_WAIT is a stall after a data byte. The named transitions are these:
- header-accept moves from IDLE or either phase into a phase.
- header-refuse goes to IDLE.
- header-hold goes to HDR_WAIT.
- byte-hold goes from a phase to BYTE_WAIT.
- resume goes from a stall back to a phase.
- resume-refuse goes from a stall to IDLE.

Top module: `i2c_tgt_resp_ctrl`

## Requirements
- R1: After reset the register reads 0, and ack_valid, ack_nack, pending, stall and both DMA requests are 0.
- R2: A register write stores bits 3, 8 and 9. A read returns those three bits in place and 0 in every other position, including bits 0 and 1.
- R3: A header with hdr_match=0 seen outside a stall gives ack_valid=1 with ack_nack=1 in the next cycle and leaves pending at 0.
- R4: With bit 8 set, a matching header whose hdr_rw (1 = read) equals bit 9 gives ack_valid=1 with ack_nack=0 in the next cycle, without pending, and opens TX_PHASE for a read or RX_PHASE for a write.
- R5: With bit 8 set, a matching header of the other direction is refused (ack_valid=1, ack_nack=1) when auto_nack=1, and enters HDR_WAIT (pending=1) when auto_nack=0.
- R6: With bit 8 clear, a matching header enters HDR_WAIT when auto_nack=0 and is refused when auto_nack=1.
- R7: While pending, stall stays 1 until a write with bit 0 set. In the next cycle pending and stall fall, and a decision is issued (ack_valid=1, ack_nack = bit 1 of that write). The target then returns to IDLE if ack_nack=1, or to the phase of the transfer otherwise.
- R8: A write with bit 0 set while pending is 0 has no effect: no ack_valid, and pending stays 0.
- R9: In RX_PHASE a byte-complete with bit 3 set is acknowledged at once (ack_valid=1, ack_nack=0). With bit 3 clear it enters BYTE_WAIT.
- R10: In TX_PHASE a byte-complete with bit 3 clear enters BYTE_WAIT. The continue that ends it issues no ack_valid, ignores bit 1, and returns to TX_PHASE. With bit 3 set the byte causes no stall.
- R11: dma_tx_req is 1 one cycle after a cycle with bit 3 set, TX_PHASE and txbuf_empty=1. dma_rx_req is 1 one cycle after a cycle with bit 3 set, RX_PHASE and rxbyte_ready=1. Otherwise each is 0, so it falls one cycle after the byte is serviced.
- R12: A header arriving during TX_PHASE or RX_PHASE (a repeated start) is decided exactly as in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control register write data |
| ctl_rdata | output | 32 | Control register read value |
| hdr_valid | input | 1 | One-cycle header-received event |
| hdr_match | input | 1 | Header address matched the primary address |
| hdr_rw | input | 1 | Header direction, 1 = read |
| auto_nack | input | 1 | Refuse headers that are not auto-acknowledged |
| byte_done | input | 1 | One-cycle data-byte-complete event |
| txbuf_empty | input | 1 | Transmit buffer needs a byte |
| rxbyte_ready | input | 1 | A received byte waits to be taken |
| ack_valid | output | 1 | One-cycle decision strobe |
| ack_nack | output | 1 | Decision, 1 = NACK (valid with ack_valid) |
| pending | output | 1 | Software attention flag |
| stall | output | 1 | Hold the bus clock low |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |

## Verification
The properties assume that the bus layer sends no header or byte-complete event while the block stalls, because a stretched clock cannot deliver one. They also assume that byte-complete never coincides with a header. The stimulus drives every event for a single cycle, drives them only between stalls, and never drives two events in the same cycle. Under these assumptions a decision strobe has exactly one cause. Continue and refuse strobes are also written while no stall is open, so the checks confirm that they do nothing there.

// File: rtl/tgt_resp_pkg.sv
package tgt_resp_pkg;

    // Control register bit positions (software depends on them)
    localparam int BIT_GO     = 0;
    localparam int BIT_REFUSE = 1;
    localparam int BIT_DMA    = 3;
    localparam int BIT_AUTO   = 8;
    localparam int BIT_EXPRD  = 9;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_HDR_WAIT  = 3'd1,
        ST_TX_PHASE  = 3'd2,
        ST_RX_PHASE  = 3'd3,
        ST_BYTE_WAIT = 3'd4
    } resp_state_e;

    typedef struct packed {
        logic dma_en;
        logic auto_ack;
        logic exp_read;
    } tgt_cfg_t;

endpackage

// File: rtl/tgt_ctl_regs.sv
module tgt_ctl_regs
    import tgt_resp_pkg::*;
#(
    parameter int CTL_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wdata,
    output tgt_cfg_t         cfg,
    output logic             go,
    output logic             refuse,
    output logic [CTL_W-1:0] rdata
);

    tgt_cfg_t cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q <= '{dma_en:   wdata[BIT_DMA],
                       auto_ack: wdata[BIT_AUTO],
                       exp_read: wdata[BIT_EXPRD]};
        end
    end

    // action strobes live only in the write cycle
    assign go     = wr_en & wdata[BIT_GO];
    assign refuse = wdata[BIT_REFUSE];
    assign cfg    = cfg_q;

    generate
        for (genvar b = 0; b < CTL_W; b++) begin : g_rd
            if (b == BIT_DMA) begin : g_dma
                assign rdata[b] = cfg_q.dma_en;
            end else if (b == BIT_AUTO) begin : g_auto
                assign rdata[b] = cfg_q.auto_ack;
            end else if (b == BIT_EXPRD) begin : g_exp
                assign rdata[b] = cfg_q.exp_read;
            end else begin : g_zero
                assign rdata[b] = 1'b0;
            end
        end
    endgenerate

    logic unused_wbits;
    assign unused_wbits = ^wdata;

endmodule

// File: rtl/tgt_resp_fsm.sv
module tgt_resp_fsm
    import tgt_resp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  tgt_cfg_t    cfg,
    input  logic        go,
    input  logic        refuse,
    input  logic        hdr_valid,
    input  logic        hdr_match,
    input  logic        hdr_rw,
    input  logic        auto_nack,
    input  logic        byte_done,
    output resp_state_e state,
    output logic        ack_valid,
    output logic        ack_nack,
    output logic        pending
);

    resp_state_e state_q, state_d;
    logic        rd_q, rd_d;
    logic        emit_d, nack_d;

    // next state and decision
    always_comb begin
        state_d = state_q;
        rd_d    = rd_q;
        emit_d  = 1'b0;
        nack_d  = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_TX_PHASE, ST_RX_PHASE: begin
                if (hdr_valid) begin
                    if (!hdr_match) begin
                        emit_d  = 1'b1;
                        nack_d  = 1'b1;
                        state_d = ST_IDLE;
                    end else if (cfg.auto_ack && (hdr_rw == cfg.exp_read)) begin
                        emit_d  = 1'b1;
                        rd_d    = hdr_rw;
                        state_d = hdr_rw ? ST_TX_PHASE : ST_RX_PHASE;
                    end else if (auto_nack) begin
                        emit_d  = 1'b1;
                        nack_d  = 1'b1;
                        state_d = ST_IDLE;
                    end else begin
                        rd_d    = hdr_rw;
                        state_d = ST_HDR_WAIT;
                    end
                end else if (byte_done && (state_q == ST_RX_PHASE)) begin
                    if (cfg.dma_en) begin
                        emit_d = 1'b1;
                    end else begin
                        state_d = ST_BYTE_WAIT;
                    end
                end else if (byte_done && (state_q == ST_TX_PHASE)) begin
                    if (!cfg.dma_en) begin
                        state_d = ST_BYTE_WAIT;
                    end
                end
            end
            ST_HDR_WAIT: begin
                if (go) begin
                    emit_d  = 1'b1;
                    nack_d  = refuse;
                    state_d = refuse ? ST_IDLE :
                              (rd_q ? ST_TX_PHASE : ST_RX_PHASE);
                end
            end
            ST_BYTE_WAIT: begin
                if (go) begin
                    if (rd_q) begin
                        state_d = ST_TX_PHASE;
                    end else begin
                        emit_d  = 1'b1;
                        nack_d  = refuse;
                        state_d = refuse ? ST_IDLE : ST_RX_PHASE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rd_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            rd_q    <= rd_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_valid <= 1'b0;
            ack_nack  <= 1'b0;
        end else begin
            ack_valid <= emit_d;
            ack_nack  <= emit_d & nack_d;
        end
    end

    assign state   = state_q;
    assign pending = (state_q == ST_HDR_WAIT) || (state_q == ST_BYTE_WAIT);

endmodule

// File: rtl/tgt_dma_req.sv
module tgt_dma_req
    import tgt_resp_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dma_en,
    input  resp_state_e       state,
    input  logic [NUM_CH-1:0] buf_flag,
    output logic [NUM_CH-1:0] req
);

    // channel 0 serves transmit phases, channel 1 receive phases
    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            localparam resp_state_e PHASE = (c == 0) ? ST_TX_PHASE : ST_RX_PHASE;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    req[c] <= 1'b0;
                end else begin
                    req[c] <= dma_en && (state == PHASE) && buf_flag[c];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/i2c_tgt_resp_ctrl.sv
module i2c_tgt_resp_ctrl
    import tgt_resp_pkg::*;
#(
    parameter int CTL_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic [CTL_W-1:0] ctl_rdata,
    input  logic             hdr_valid,
    input  logic             hdr_match,
    input  logic             hdr_rw,
    input  logic             auto_nack,
    input  logic             byte_done,
    input  logic             txbuf_empty,
    input  logic             rxbyte_ready,
    output logic             ack_valid,
    output logic             ack_nack,
    output logic             pending,
    output logic             stall,
    output logic             dma_tx_req,
    output logic             dma_rx_req
);

    localparam int NUM_CH = 2;

    tgt_cfg_t          cfg;
    logic              go, refuse;
    resp_state_e       state;
    logic [NUM_CH-1:0] dreq;

    tgt_ctl_regs #(.CTL_W(CTL_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (ctl_wr),
        .wdata  (ctl_wdata),
        .cfg    (cfg),
        .go     (go),
        .refuse (refuse),
        .rdata  (ctl_rdata)
    );

    tgt_resp_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (cfg),
        .go        (go),
        .refuse    (refuse),
        .hdr_valid (hdr_valid),
        .hdr_match (hdr_match),
        .hdr_rw    (hdr_rw),
        .auto_nack (auto_nack),
        .byte_done (byte_done),
        .state     (state),
        .ack_valid (ack_valid),
        .ack_nack  (ack_nack),
        .pending   (pending)
    );

    tgt_dma_req #(.NUM_CH(NUM_CH)) u_dma (
        .clk      (clk),
        .rst_n    (rst_n),
        .dma_en   (cfg.dma_en),
        .state    (state),
        .buf_flag ({rxbyte_ready, txbuf_empty}),
        .req      (dreq)
    );

    assign stall      = pending;
    assign dma_tx_req = dreq[0];
    assign dma_rx_req = dreq[1];

endmodule

// File: rtl/tgt_resp_chk.sv
module tgt_resp_chk
    import tgt_resp_pkg::*;
#(
    parameter int CTL_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_wr,
    input logic [CTL_W-1:0] ctl_wdata,
    input logic [CTL_W-1:0] ctl_rdata,
    input logic             hdr_valid,
    input logic             hdr_match,
    input logic             hdr_rw,
    input logic             auto_nack,
    input logic             byte_done,
    input logic             ack_valid,
    input logic             ack_nack,
    input logic             pending,
    input logic             dma_tx_req,
    input logic             dma_rx_req
);

    assert_nomatch_nack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && !hdr_match && !pending) |=> (ack_valid && ack_nack && !pending));

    assert_auto_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && hdr_match && ctl_rdata[BIT_AUTO] &&
         (hdr_rw == ctl_rdata[BIT_EXPRD]) && !pending) |=> (ack_valid && !ack_nack && !pending));

    assert_wrong_dir_nack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && hdr_match && ctl_rdata[BIT_AUTO] && auto_nack &&
         (hdr_rw != ctl_rdata[BIT_EXPRD]) && !pending) |=> (ack_valid && ack_nack));

    assert_manual_nack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && hdr_match && !ctl_rdata[BIT_AUTO] && auto_nack && !pending)
        |=> (ack_valid && ack_nack));

    assert_resume_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && ctl_wr && ctl_wdata[BIT_GO]) |=> !pending);

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !(ctl_wr && ctl_wdata[BIT_GO])) |=> (pending && !ack_valid));

    assert_idle_go_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!pending && ctl_wr && ctl_wdata[BIT_GO] && !hdr_valid && !byte_done)
        |=> (!ack_valid && !pending));

    assert_dma_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_rdata[BIT_DMA] |=> (!dma_tx_req && !dma_rx_req));

    assert_dma_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dma_tx_req, dma_rx_req}));

endmodule

bind i2c_tgt_resp_ctrl tgt_resp_chk #(.CTL_W(CTL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_wr     (ctl_wr),
    .ctl_wdata  (ctl_wdata),
    .ctl_rdata  (ctl_rdata),
    .hdr_valid  (hdr_valid),
    .hdr_match  (hdr_match),
    .hdr_rw     (hdr_rw),
    .auto_nack  (auto_nack),
    .byte_done  (byte_done),
    .ack_valid  (ack_valid),
    .ack_nack   (ack_nack),
    .pending    (pending),
    .dma_tx_req (dma_tx_req),
    .dma_rx_req (dma_rx_req)
);

// File: tb/test_i2c_tgt_resp_ctrl.sv
module test_i2c_tgt_resp_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic [31:0] ctl_rdata;
    logic        hdr_valid = 1'b0, hdr_match = 1'b0, hdr_rw = 1'b0;
    logic        auto_nack = 1'b0, byte_done = 1'b0;
    logic        txbuf_empty = 1'b0, rxbyte_ready = 1'b0;
    logic        ack_valid, ack_nack, pending, stall, dma_tx_req, dma_rx_req;

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    i2c_tgt_resp_ctrl i_i2c_tgt_resp_ctrl (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .hdr_valid(hdr_valid), .hdr_match(hdr_match),
        .hdr_rw(hdr_rw), .auto_nack(auto_nack), .byte_done(byte_done),
        .txbuf_empty(txbuf_empty), .rxbyte_ready(rxbyte_ready),
        .ack_valid(ack_valid), .ack_nack(ack_nack), .pending(pending),
        .stall(stall), .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req)
    );

    // ---------------- behavioural reference model ----------------
    // mode: 0 none, 1 waiting on header, 2 reading, 3 writing, 4 waiting on byte
    int   m_mode = 0;
    bit   m_read = 0;
    bit   m_dma = 0, m_auto = 0, m_exp = 0;
    bit   m_av = 0, m_an = 0, m_tx = 0, m_rx = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_read = 0; m_dma = 0; m_auto = 0; m_exp = 0;
            m_av = 0; m_an = 0; m_tx = 0; m_rx = 0;
        end else begin
            bit cont;
            int nxt;
            cont = ctl_wr && ctl_wdata[0];
            m_tx = m_dma && (m_mode == 2) && txbuf_empty;
            m_rx = m_dma && (m_mode == 3) && rxbyte_ready;
            m_av = 0; m_an = 0; nxt = m_mode;
            if (m_mode == 1 || m_mode == 4) begin
                if (cont) begin
                    if (m_mode == 4 && m_read) nxt = 2;
                    else begin
                        m_av = 1; m_an = ctl_wdata[1];
                        nxt = ctl_wdata[1] ? 0 : (m_read ? 2 : 3);
                    end
                end
            end else if (hdr_valid) begin
                if (!hdr_match) begin m_av = 1; m_an = 1; nxt = 0; end
                else if (m_auto && hdr_rw == m_exp) begin
                    m_av = 1; m_read = hdr_rw; nxt = hdr_rw ? 2 : 3;
                end else if (auto_nack) begin m_av = 1; m_an = 1; nxt = 0; end
                else begin m_read = hdr_rw; nxt = 1; end
            end else if (byte_done && m_mode == 3) begin
                if (m_dma) m_av = 1; else nxt = 4;
            end else if (byte_done && m_mode == 2) begin
                if (!m_dma) nxt = 4;
            end
            m_mode = nxt;
            if (ctl_wr) begin
                m_dma = ctl_wdata[3]; m_auto = ctl_wdata[8]; m_exp = ctl_wdata[9];
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare against the model every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(cur_req, {ctl_rdata[31:0]},
                {22'd0, m_exp, m_auto, 4'd0, m_dma, 3'd0});
            chk(cur_req, {26'd0, ack_valid, ack_nack, pending, stall, dma_tx_req, dma_rx_req},
                {26'd0, m_av, m_av & m_an, (m_mode == 1 || m_mode == 4),
                 (m_mode == 1 || m_mode == 4), m_tx, m_rx});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [31:0] v);
        @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_wr = 1'b0; ctl_wdata = '0;
    endtask

    task automatic hdr(input logic m, input logic rw, input logic an);
        @(negedge clk); hdr_valid = 1'b1; hdr_match = m; hdr_rw = rw; auto_nack = an;
        @(negedge clk); hdr_valid = 1'b0; hdr_match = 1'b0; hdr_rw = 1'b0;
    endtask

    task automatic bdone();
        @(negedge clk); byte_done = 1'b1;
        @(negedge clk); byte_done = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", ctl_rdata, 32'h0);
        chk("R1", {ack_valid, pending, stall, dma_tx_req, dma_rx_req}, 5'b0);

        cur_req = "R2";
        wr(32'hFFFF_FFFF);
        chk("R2", ctl_rdata, 32'h0000_0308);
        chk("R8", {ack_valid, pending}, 2'b00);
        wr(32'h0);
        chk("R2", ctl_rdata, 32'h0);

        cur_req = "R3";
        hdr(1'b0, 1'b1, 1'b0);
        chk("R3", {ack_valid, ack_nack, pending}, 3'b110);

        cur_req = "R4";
        wr(32'h100);                    // auto on, expect write
        hdr(1'b1, 1'b0, 1'b0);
        chk("R4", {ack_valid, ack_nack, pending}, 3'b100);

        cur_req = "R12";
        hdr(1'b1, 1'b1, 1'b1);          // repeated start, wrong direction, auto-nack
        chk("R5", {ack_valid, ack_nack, pending}, 3'b110);
        chk("R12", {ack_valid, ack_nack}, 2'b11);

        cur_req = "R5";
        hdr(1'b1, 1'b1, 1'b0);
        chk("R5", {ack_valid, pending, stall}, 3'b011);
        repeat (4) @(negedge clk);
        chk("R7", {pending, stall}, 2'b11);
        cur_req = "R7";
        wr(32'h101);
        chk("R7", {ack_valid, ack_nack, pending, stall}, 4'b1000);

        cur_req = "R10";                // now reading, DMA off
        bdone();
        chk("R10", {ack_valid, pending}, 2'b01);
        wr(32'h103);                    // refuse bit must be ignored
        chk("R10", {ack_valid, pending}, 2'b00);
        bdone();
        chk("R10", pending, 1'b1);
        wr(32'h101);

        cur_req = "R11";
        wr(32'h109);                    // DMA on
        @(negedge clk); txbuf_empty = 1'b1;
        @(negedge clk);
        chk("R11", {dma_tx_req, dma_rx_req}, 2'b10);
        txbuf_empty = 1'b0;
        @(negedge clk);
        chk("R11", dma_tx_req, 1'b0);
        bdone();
        chk("R10", {ack_valid, pending}, 2'b00);

        cur_req = "R6";
        wr(32'h008);                    // auto off, DMA on
        hdr(1'b1, 1'b0, 1'b0);
        chk("R6", {ack_valid, pending}, 2'b01);
        wr(32'h009);
        chk("R7", {ack_valid, ack_nack, pending}, 3'b100);
        cur_req = "R11";
        @(negedge clk); rxbyte_ready = 1'b1;
        @(negedge clk);
        chk("R11", {dma_tx_req, dma_rx_req}, 2'b01);
        rxbyte_ready = 1'b0;
        cur_req = "R9";
        bdone();
        chk("R9", {ack_valid, ack_nack, pending}, 3'b100);
        wr(32'h000);
        bdone();
        chk("R9", {ack_valid, pending}, 2'b01);
        wr(32'h003);
        chk("R7", {ack_valid, ack_nack, pending}, 3'b110);
        @(negedge clk); rxbyte_ready = 1'b1;
        repeat (2) @(negedge clk);
        chk("R11", dma_rx_req, 1'b0);
        rxbyte_ready = 1'b0;

        cur_req = "R6";
        hdr(1'b1, 1'b0, 1'b1);
        chk("R6", {ack_valid, ack_nack, pending}, 3'b110);

        cur_req = "R8";
        wr(32'h001);
        chk("R8", {ack_valid, pending}, 2'b00);

        cur_req = "R4";
        wr(32'h300);                    // auto on, expect read
        hdr(1'b1, 1'b1, 1'b1);
        chk("R4", {ack_valid, ack_nack, pending}, 3'b100);

        repeat (3) @(negedge clk);
        summary();
        $finish;
    end

endmodule